// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block collects the events of an SD/MMC host controller and turns them into one interrupt line. Pulses from the command/response engine, the data engine and the card-detect logic are caught in sticky status bits. Software reads and writes these bits through a byte-wide register port. Writing a one to a status bit clears it. Writing a zero leaves it alone. Two mask bytes choose which status bits raise the interrupt. The interrupt output is a register that is high while any enabled status bit is set.

The unit also holds the command control byte. This byte has a start bit, a write-direction bit, a response-FIFO reset bit and a four-bit command type. The start and FIFO-reset bits clear themselves after one cycle, so the command engine sees a single-cycle strobe on each of them. The card-detect pin, the card-detect level on DATA3 and the write-protect pin are asynchronous inputs, and each passes through a synchronizer. A level change on the card-detect pin is itself latched as a status event. A further byte shows the two engine busy flags live, and it holds one writable bit that allows the card clock to freeze automatically.

Top module: `sdh_evt_irq`

## Requirements
- R1: After reset, every register reads 0x00, and irq_o, cmd_start_o, cmd_write_o, fifo_rst_o, cmd_type_o and clk_freeze_en_o are all 0.
- R2: The register map is addressed through bus_addr_i. The sticky event bits are as follows. Command status (address 4): cmd_evt_i bit n sets bit n, where bit0 = SDIO interrupt, bit1 = command/response done, bit2 = response timeout, bit3 = auto-stop done, bit4 = data timeout, bit5 = response CRC error, bit6 = read CRC error and bit7 = write CRC error. Card/data status (address 3): ev_mblk_i sets bit4, ev_blk_i sets bit5, a card-detect pin change sets bit6 and ev_ins_i sets bit7. A set bit stays set until software clears it.
- R3: Clearing status by writing: writing a 1 to a sticky bit at address 3 or 4 clears that bit, and writing a 0 leaves it unchanged, so 0xFF clears the whole byte.
- R4: When an event and a software clear hit the same bit in the same cycle, the bit stays set.
- R5: irq_o is registered. It is 1 in the cycle after any status bit and its mask bit are both set. Otherwise it is 0. The masks sit at address 1 (bits 7:4, matching status bits 7:4 at address 3) and at address 2 (bits 7:1, matching the command status bits at address 4).
- R6: Address 3 shows the synchronized levels of three pins: bit1 = wp_i, bit2 = cd_dat3_i and bit3 = cd_pin_i. Bit0 reads 0. Each level appears SYNC_STAGES clock edges after the pin changes. One edge later, a change of cd_pin_i sets sticky bit6. Writes have no effect on bits 3:0.
- R7: Control byte (address 0). Bit0 is the command start, bit2 the write direction, bit3 the response-FIFO reset, and bits 7:4 the command type (0 no data, 1 single-block write, 2 single-block read, 3 multi-block write, 4 multi-block read, 7 stop). Bits 0 and 3 drive cmd_start_o and fifo_rst_o for exactly one cycle after the write and then read back 0. Bits 2 and 7:4 are held and drive cmd_write_o and cmd_type_o. Bit1 always reads 0.
- R8: Busy and clock byte (address 5). Bit4 shows cmd_busy_i live and bit5 shows dat_busy_i live, and writes have no effect on either bit. Bit7 is a read/write bit that drives clk_freeze_en_o. All other bits read 0. Address 6 and any address above it read 0x00 and ignore writes.
- R9: Only the implemented mask bits are stored: bits 7:4 at address 1 and bits 7:1 at address 2. All other mask bits read 0. Command status bit0 (SDIO) therefore never raises irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from bus_addr_i |
| ev_mblk_i | input | 1 | Multi-block transfer done pulse |
| ev_blk_i | input | 1 | Block transfer done pulse |
| ev_ins_i | input | 1 | Device inserted pulse |
| cmd_evt_i | input | 8 | Command engine event pulses, one per command status bit |
| cmd_busy_i | input | 1 | Command/response path busy |
| dat_busy_i | input | 1 | Data response busy |
| wp_i | input | 1 | Write-protect pin (asynchronous) |
| cd_dat3_i | input | 1 | Card-detect level on DATA3 (asynchronous) |
| cd_pin_i | input | 1 | Card-detect pin (asynchronous) |
| cmd_start_o | output | 1 | One-cycle command start strobe |
| cmd_write_o | output | 1 | Data direction is write |
| fifo_rst_o | output | 1 | One-cycle response FIFO reset strobe |
| cmd_type_o | output | 4 | Command type field |
| clk_freeze_en_o | output | 1 | Automatic clock freezing allowed |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is an event pulse and a write-one-to-clear of the same bit landing on the same clock edge. Another is an event that arrives while its mask is being changed, so that the registered interrupt must follow both updates in the same cycle. A seeded random phase drives writes to the masks and status bytes with sparse event pulses on every cycle, which makes these collisions frequent. A bench model predicts every byte and the interrupt. Directed steps force the exact collision and also walk the card-detect change through the synchronizer.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

    localparam int unsigned REG_W = 8;

    // register addresses
    typedef enum logic [2:0] {
        A_CTL  = 3'd0,
        A_MSK0 = 3'd1,
        A_MSK1 = 3'd2,
        A_ST0  = 3'd3,
        A_ST1  = 3'd4,
        A_ST2  = 3'd5,
        A_ST3  = 3'd6
    } reg_addr_e;

    // command type field values
    typedef enum logic [3:0] {
        CK_NONE = 4'd0,
        CK_WR1  = 4'd1,
        CK_RD1  = 4'd2,
        CK_WRN  = 4'd3,
        CK_RDN  = 4'd4,
        CK_STOP = 4'd7
    } cmd_kind_e;

    // bit positions the engines and software decode
    localparam int unsigned ST0_WP     = 1;
    localparam int unsigned ST0_MBLK   = 4;
    localparam int unsigned ST0_BLK    = 5;
    localparam int unsigned ST0_CD_CHG = 6;
    localparam int unsigned ST0_INS    = 7;
    localparam int unsigned ST2_CBUSY  = 4;
    localparam int unsigned ST2_DBUSY  = 5;
    localparam int unsigned ST2_FRZ    = 7;
    localparam int unsigned CTL_START  = 0;
    localparam int unsigned CTL_WDIR   = 2;
    localparam int unsigned CTL_FRST   = 3;
    localparam int unsigned CTL_TLSB   = 4;

    localparam logic [REG_W-1:0] MSK0_IMPL  = 8'hF0;
    localparam logic [REG_W-1:0] MSK1_IMPL  = 8'hFE;
    localparam logic [REG_W-1:0] ST0_STICKY = 8'hF0;
    localparam logic [REG_W-1:0] ST1_STICKY = 8'hFF;
    localparam logic [REG_W-1:0] CTL_KEEP   = 8'hFD;
    localparam logic [REG_W-1:0] CTL_PULSE  = 8'h09;

endpackage

// File: rtl/sdh_lvl_sync.sv
module sdh_lvl_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] chg_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
        logic [W-1:0]             prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stg[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stg[i] = s_q.stg[i-1];
        end
        s_d.prev = s_q.stg[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign lvl_o = s_q.stg[STAGES-1];
    assign chg_o = s_q.stg[STAGES-1] ^ s_q.prev;
endmodule

// File: rtl/sdh_sticky_bank.sv
module sdh_sticky_bank #(
    parameter int unsigned   W    = 8,
    parameter logic [W-1:0]  KEEP = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] bits_o,
    output logic [W-1:0] nxt_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d      = b_q;
        // a set in the same cycle overrides a clear
        b_d.bits = ((b_q.bits & ~clr_i) | set_i) & KEEP;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) b_q <= '0;
        else         b_q <= b_d;
    end

    assign bits_o = b_q.bits;
    assign nxt_o  = b_d.bits;
endmodule

// File: rtl/sdh_mask_reg.sv
module sdh_mask_reg #(
    parameter int unsigned  W    = 8,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] nxt_o
);
    typedef struct packed {
        logic [W-1:0] m;
    } msk_t;

    msk_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (we_i) m_d.m = wdata_i & IMPL;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) m_q <= '0;
        else         m_q <= m_d;
    end

    assign mask_o = m_q.m;
    assign nxt_o  = m_d.m;
endmodule

// File: rtl/sdh_ctl_reg.sv
module sdh_ctl_reg
    import sdh_irq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] ctl_o
);
    typedef struct packed {
        logic [REG_W-1:0] ctl;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        // strobe bits fall back to zero one cycle after they were written
        c_d.ctl = c_q.ctl & ~CTL_PULSE;
        if (we_i) c_d.ctl = wdata_i & CTL_KEEP;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign ctl_o = c_q.ctl;
endmodule

// File: rtl/sdh_evt_irq.sv
module sdh_evt_irq
    import sdh_irq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    input  logic              ev_mblk_i,
    input  logic              ev_blk_i,
    input  logic              ev_ins_i,
    input  logic [REG_W-1:0]  cmd_evt_i,
    input  logic              cmd_busy_i,
    input  logic              dat_busy_i,
    input  logic              wp_i,
    input  logic              cd_dat3_i,
    input  logic              cd_pin_i,
    output logic              cmd_start_o,
    output logic              cmd_write_o,
    output logic              fifo_rst_o,
    output logic [3:0]        cmd_type_o,
    output logic              clk_freeze_en_o,
    output logic              irq_o
);
    localparam int unsigned NPIN = 3;
    localparam logic [NPIN-1:0] PIN_CD_SEL = 3'b100;

    typedef struct packed {
        logic frz;
        logic irq;
    } top_t;

    top_t t_d, t_q;

    logic wr_ctl, wr_m0, wr_m1, wr_s0, wr_s1, wr_s2;
    logic [NPIN-1:0]  pin_lvl, pin_chg;
    logic             cd_chg;
    logic [REG_W-1:0] st0_set, st0_clr, st1_clr;
    logic [REG_W-1:0] st0_q, st0_nxt, st1_q, st1_nxt;
    logic [REG_W-1:0] m0_q, m0_nxt, m1_q, m1_nxt;
    logic [REG_W-1:0] ctl_q;

    assign wr_ctl = bus_we_i && (bus_addr_i == ADDR_W'(A_CTL));
    assign wr_m0  = bus_we_i && (bus_addr_i == ADDR_W'(A_MSK0));
    assign wr_m1  = bus_we_i && (bus_addr_i == ADDR_W'(A_MSK1));
    assign wr_s0  = bus_we_i && (bus_addr_i == ADDR_W'(A_ST0));
    assign wr_s1  = bus_we_i && (bus_addr_i == ADDR_W'(A_ST1));
    assign wr_s2  = bus_we_i && (bus_addr_i == ADDR_W'(A_ST2));

    // pin order {card-detect pin, DATA3 detect, write protect}
    sdh_lvl_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({cd_pin_i, cd_dat3_i, wp_i}),
        .lvl_o   (pin_lvl),
        .chg_o   (pin_chg)
    );

    assign cd_chg = |(pin_chg & PIN_CD_SEL);

    always_comb begin
        st0_set             = '0;
        st0_set[ST0_MBLK]   = ev_mblk_i;
        st0_set[ST0_BLK]    = ev_blk_i;
        st0_set[ST0_CD_CHG] = cd_chg;
        st0_set[ST0_INS]    = ev_ins_i;
        st0_clr             = wr_s0 ? bus_wdata_i : '0;
        st1_clr             = wr_s1 ? bus_wdata_i : '0;
    end

    sdh_sticky_bank #(.W(REG_W), .KEEP(ST0_STICKY)) u_st0 (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (st0_set),
        .clr_i  (st0_clr),
        .bits_o (st0_q),
        .nxt_o  (st0_nxt)
    );

    sdh_sticky_bank #(.W(REG_W), .KEEP(ST1_STICKY)) u_st1 (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (cmd_evt_i),
        .clr_i  (st1_clr),
        .bits_o (st1_q),
        .nxt_o  (st1_nxt)
    );

    sdh_mask_reg #(.W(REG_W), .IMPL(MSK0_IMPL)) u_m0 (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_m0),
        .wdata_i (bus_wdata_i),
        .mask_o  (m0_q),
        .nxt_o   (m0_nxt)
    );

    sdh_mask_reg #(.W(REG_W), .IMPL(MSK1_IMPL)) u_m1 (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_m1),
        .wdata_i (bus_wdata_i),
        .mask_o  (m1_q),
        .nxt_o   (m1_nxt)
    );

    sdh_ctl_reg u_ctl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_ctl),
        .wdata_i (bus_wdata_i),
        .ctl_o   (ctl_q)
    );

    always_comb begin
        t_d = t_q;
        if (wr_s2) t_d.frz = bus_wdata_i[ST2_FRZ];
        // built from next-state values so the flop matches the registers it follows
        t_d.irq = (|(st0_nxt & m0_nxt)) | (|(st1_nxt & m1_nxt));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_W'(A_CTL):  bus_rdata_o = ctl_q;
            ADDR_W'(A_MSK0): bus_rdata_o = m0_q;
            ADDR_W'(A_MSK1): bus_rdata_o = m1_q;
            ADDR_W'(A_ST0): begin
                bus_rdata_o = st0_q;
                bus_rdata_o[ST0_WP +: NPIN] = pin_lvl;
            end
            ADDR_W'(A_ST1):  bus_rdata_o = st1_q;
            ADDR_W'(A_ST2): begin
                bus_rdata_o[ST2_CBUSY] = cmd_busy_i;
                bus_rdata_o[ST2_DBUSY] = dat_busy_i;
                bus_rdata_o[ST2_FRZ]   = t_q.frz;
            end
            default:         bus_rdata_o = '0;
        endcase
    end

    assign cmd_start_o     = ctl_q[CTL_START];
    assign cmd_write_o     = ctl_q[CTL_WDIR];
    assign fifo_rst_o      = ctl_q[CTL_FRST];
    assign cmd_type_o      = ctl_q[CTL_TLSB +: 4];
    assign clk_freeze_en_o = t_q.frz;
    assign irq_o           = t_q.irq;
endmodule

// File: rtl/sdh_evt_irq_chk.sv
module sdh_evt_irq_chk
    import sdh_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [REG_W-1:0]  bus_wdata_i,
    input logic [REG_W-1:0]  cmd_evt_i,
    input logic              cmd_start_o,
    input logic              fifo_rst_o,
    input logic              irq_o,
    input logic [REG_W-1:0]  st0_q,
    input logic [REG_W-1:0]  st1_q,
    input logic [REG_W-1:0]  m0_q,
    input logic [REG_W-1:0]  m1_q
);
    logic st1_clear_wr;
    assign st1_clear_wr = bus_we_i && (bus_addr_i == ADDR_W'(A_ST1)) && (bus_wdata_i != '0);

    p_start_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_start_o |=> !cmd_start_o);

    p_fifo_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_rst_o |=> !fifo_rst_o);

    p_evt_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_evt_i != '0) |=> ((st1_q & $past(cmd_evt_i)) == $past(cmd_evt_i)));

    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st1_clear_wr |=> ((st1_q & $past(st1_q)) == $past(st1_q)));

    p_irq_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == ((|(st0_q & m0_q)) || (|(st1_q & m1_q))));

    p_mask_impl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m1_q[0] == 1'b0) && (m0_q[3:0] == 4'h0));
endmodule

bind sdh_evt_irq sdh_evt_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .cmd_evt_i   (cmd_evt_i),
    .cmd_start_o (cmd_start_o),
    .fifo_rst_o  (fifo_rst_o),
    .irq_o       (irq_o),
    .st0_q       (st0_q),
    .st1_q       (st1_q),
    .m0_q        (m0_q),
    .m1_q        (m1_q)
);

// File: tb/sdh_evt_irq_tb.sv
`timescale 1ns/1ps
module sdh_evt_irq_tb_top;
    import sdh_irq_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ev_mblk = 1'b0, ev_blk = 1'b0, ev_ins = 1'b0;
    logic [7:0] cmd_evt = '0;
    logic       cbusy = 1'b0, dbusy = 1'b0;
    logic       wp = 1'b0, dat3 = 1'b0, pin = 1'b0;
    logic       start_o, write_o, frst_o, frz_o, irq;
    logic [3:0] type_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic finished = 1'b0;

    // bench model state
    logic [7:0] m_s0 = '0, m_s1 = '0, m_k0 = '0, m_k1 = '0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdh_evt_irq dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ev_mblk_i(ev_mblk),
        .ev_blk_i(ev_blk), .ev_ins_i(ev_ins), .cmd_evt_i(cmd_evt),
        .cmd_busy_i(cbusy), .dat_busy_i(dbusy), .wp_i(wp), .cd_dat3_i(dat3),
        .cd_pin_i(pin), .cmd_start_o(start_o), .cmd_write_o(write_o),
        .fifo_rst_o(frst_o), .cmd_type_o(type_o), .clk_freeze_en_o(frz_o),
        .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // one clock: apply at the falling edge, leave the bench just after the rising edge
    task automatic step(input logic w, input logic [2:0] a, input logic [7:0] d,
                        input logic [2:0] dev, input logic [7:0] ce);
        @(negedge clk);
        we = w; addr = a; wdata = d;
        {ev_ins, ev_blk, ev_mblk} = dev;
        cmd_evt = ce;
        @(posedge clk);
        #1;
        we = 1'b0; ev_ins = 1'b0; ev_blk = 1'b0; ev_mblk = 1'b0; cmd_evt = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic logic [7:0] next_st(input logic [7:0] cur, input logic [7:0] clr,
                                           input logic [7:0] set, input logic [7:0] keep);
        return ((cur & ~clr) | set) & keep;
    endfunction

    function automatic logic exp_irq(input logic [7:0] s0, input logic [7:0] s1,
                                     input logic [7:0] k0, input logic [7:0] k1);
        return (|(s0 & k0)) | (|(s1 & k1));
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        wait (cyc >= 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reset read", v, 8'h00);
        end
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 ctl outs", {2'b0, frz_o, start_o, write_o, frst_o, 2'b0}, 8'h00);
        chk("R1 type", {4'b0, type_o}, 8'h00);

        // random phase: masks and status writes mixed with sparse events (R2 R3 R4 R5)
        for (int i = 0; i < 2000; i++) begin
            logic       w;
            logic [2:0] a;
            logic [7:0] d, ce, set0, clr0, clr1;
            logic [2:0] dev;
            w   = ($urandom % 2) == 0;
            a   = 3'(1 + ($urandom % 4));
            d   = 8'($urandom);
            ce  = 8'($urandom) & 8'($urandom) & 8'($urandom);
            dev = 3'($urandom) & 3'($urandom);
            set0 = {dev[2], 1'b0, dev[1], dev[0], 4'b0};
            clr0 = (w && a == A_ST0) ? d : 8'h00;
            clr1 = (w && a == A_ST1) ? d : 8'h00;
            m_s0 = next_st(m_s0, clr0, set0, 8'hF0);
            m_s1 = next_st(m_s1, clr1, ce, 8'hFF);
            if (w && a == A_MSK0) m_k0 = d & 8'hF0;
            if (w && a == A_MSK1) m_k1 = d & 8'hFE;
            step(w, a, d, dev, ce);
            chk("R5 irq random", {7'b0, irq}, {7'b0, exp_irq(m_s0, m_s1, m_k0, m_k1)});
            rd(A_ST1, v); chk("R2/R3 st1 random", v, m_s1);
            rd(A_ST0, v); chk("R2/R3 st0 random", v, m_s0);
        end

        // clean up for directed steps
        step(1, A_ST0, 8'hFF, 3'b000, 8'h00);
        step(1, A_ST1, 8'hFF, 3'b000, 8'h00);
        step(1, A_MSK0, 8'h00, 3'b000, 8'h00);
        step(1, A_MSK1, 8'h00, 3'b000, 8'h00);
        rd(A_ST1, v); chk("R3 clear all st1", v, 8'h00);

        // R4 same-cycle collision
        step(1, A_ST1, 8'h20, 3'b000, 8'h20);
        rd(A_ST1, v); chk("R4 event beats clear st1", v, 8'h20);
        step(1, A_ST0, 8'h20, 3'b010, 8'h00);
        rd(A_ST0, v); chk("R4 event beats clear st0", v, 8'h20);
        // R3 zero leaves, one clears
        step(1, A_ST1, 8'h00, 3'b000, 8'h00);
        rd(A_ST1, v); chk("R3 zero write keeps", v, 8'h20);
        step(1, A_ST1, 8'h20, 3'b000, 8'h00);
        rd(A_ST1, v); chk("R3 one write clears", v, 8'h00);
        step(1, A_ST0, 8'hFF, 3'b000, 8'h00);

        // R9 implemented mask bits, SDIO never interrupts
        step(1, A_MSK0, 8'hFF, 3'b000, 8'h00);
        rd(A_MSK0, v); chk("R9 mask0 bits", v, 8'hF0);
        step(1, A_MSK1, 8'hFF, 3'b000, 8'h00);
        rd(A_MSK1, v); chk("R9 mask1 bits", v, 8'hFE);
        step(0, A_CTL, 8'h00, 3'b000, 8'h01);
        chk("R9 sdio no irq", {7'b0, irq}, 8'h00);
        rd(A_ST1, v); chk("R2 sdio latched", v, 8'h01);
        step(0, A_CTL, 8'h00, 3'b000, 8'h02);
        chk("R5 irq on cmd done", {7'b0, irq}, 8'h01);
        step(1, A_ST1, 8'hFF, 3'b000, 8'h00);
        chk("R5 irq drops after clear", {7'b0, irq}, 8'h00);
        step(1, A_MSK1, 8'h00, 3'b000, 8'h00);
        step(1, A_MSK0, 8'h40, 3'b000, 8'h00);

        // R6 card-detect path
        pin = 1'b1;
        repeat (4) step(0, A_CTL, 8'h00, 3'b000, 8'h00);
        rd(A_ST0, v); chk("R6 pin level and change", v, 8'h48);
        chk("R6 change raises irq", {7'b0, irq}, 8'h01);
        wp = 1'b1; dat3 = 1'b1;
        repeat (3) step(0, A_CTL, 8'h00, 3'b000, 8'h00);
        rd(A_ST0, v); chk("R6 wp and dat3 levels", v, 8'h4E);
        step(1, A_ST0, 8'h4F, 3'b000, 8'h00);
        rd(A_ST0, v); chk("R6 level bits ignore write", v, 8'h0E);
        chk("R6 irq after clear", {7'b0, irq}, 8'h00);

        // R7 control byte
        step(1, A_CTL, {CK_RDN, 4'b1101}, 3'b000, 8'h00);
        chk("R7 strobes high", {6'b0, start_o, frst_o}, 8'h03);
        chk("R7 dir and type", {3'b0, write_o, type_o}, 8'h14);
        rd(A_CTL, v); chk("R7 ctl read first", v, 8'h4D);
        step(0, A_CTL, 8'h00, 3'b000, 8'h00);
        chk("R7 strobes once", {6'b0, start_o, frst_o}, 8'h00);
        rd(A_CTL, v); chk("R7 ctl read after", v, 8'h44);
        step(1, A_CTL, {CK_STOP, 4'b0010}, 3'b000, 8'h00);
        rd(A_CTL, v); chk("R7 bit1 reads zero", v, 8'h70);

        // R8 busy and clock byte, reserved address
        cbusy = 1'b1; dbusy = 1'b1;
        rd(A_ST2, v); chk("R8 busy live", v, 8'h30);
        step(1, A_ST2, 8'hFF, 3'b000, 8'h00);
        rd(A_ST2, v); chk("R8 freeze set", v, 8'hB0);
        chk("R8 freeze out", {7'b0, frz_o}, 8'h01);
        cbusy = 1'b0; dbusy = 1'b0;
        step(1, A_ST2, 8'h30, 3'b000, 8'h00);
        rd(A_ST2, v); chk("R8 busy not stored", v, 8'h00);
        step(1, A_ST3, 8'hFF, 3'b000, 8'h00);
        rd(A_ST3, v); chk("R8 reserved reads zero", v, 8'h00);

        finished = 1'b1;
        summary();
    end
endmodule